// File: doc/BRIEF.md
# Overcurrent hiccup fault sequencer

This block sequences fault recovery for a multi-phase buck PWM converter. It watches a single overcurrent flag from an analog comparator. When the flag is raised while the converter is running, the block tri-states every phase output on the next clock, so each gate driver turns off both of its switches. It then holds the phases off for a fixed number of phase-clock ticks and requests one soft-start. A successful soft-start returns the converter to normal running. A failed attempt restarts the full wait, and this loop repeats for as long as the block stays enabled.

The wait is counted on a one-cycle tick strobe derived from the phase clock, not on the system clock. The 5-bit voltage code is watched for the all-ones value, which means "regulator off". That value tri-states the phases and blocks a start from idle. The soft-start ramp, the PWM generation and the current comparison are outside this block. It only issues a request and reads back done and fail strobes.

Top module: `hiccup_seq`

## Requirements
- R1: After a synchronous reset, all phase tri-state controls are 1, the soft-start request is 0 and the fault output is 0.
- R2: When the flag `oc` is 1 while running (phases driven, no soft-start pending), on the next clock every phase tri-state control is 1 and `fault` is 1. All phase controls always carry the same value.
- R3: After a shutdown, the soft-start request rises exactly one clock after the WAIT_TICKS-th tick (default 2048) seen during the wait.
- R4: Clock cycles without a tick do not advance the wait.
- R5: While a soft-start is pending, `ss_req` is 1 and the phases are driven. A `ss_done` strobe with neither `ss_fail` nor `oc` returns the block to running.
- R6: During a soft-start, `ss_fail` or `oc` ends the attempt. It returns the block to the tri-stated wait, which again lasts the full WAIT_TICKS ticks.
- R7: If `ss_done` and `ss_fail` arrive in the same cycle, the attempt counts as failed.
- R8: A voltage code of 5'b11111 tri-states all phases in the same cycle in any state. In idle it also keeps the block from starting.
- R9: `fault` rises with a shutdown and stays 1 until a successful soft-start completes.
- R10: With `en` at 0, on the next clock the block is idle: phases tri-stated, no request, `fault` 0, wait count cleared. A wait after re-enabling again lasts the full WAIT_TICKS ticks.
- R11: From idle with `en` at 1 and a code other than all ones, `ss_req` is 1 on the next clock and `fault` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Controller enable |
| tick | input | 1 | One-cycle phase-clock strobe |
| oc | input | 1 | Overcurrent comparator flag |
| vid | input | 5 | Voltage code, all ones means off |
| ss_done | input | 1 | Soft-start completed strobe |
| ss_fail | input | 1 | Soft-start failed strobe |
| pwm_hiz | output | NUM_PHASES | Per-phase tri-state control, 1 = high impedance |
| ss_req | output | 1 | Soft-start request, high while an attempt runs |
| fault | output | 1 | Overcurrent fault latched |

## Verification
The state register and the wait count are only visible at the ports through `pwm_hiz`, `ss_req` and `fault`. A wrong state therefore shows as one of these outputs differing from the reference on the very next clock. A wait count that is off by even one tick, or that counts untimed cycles, shows as a shifted rise of `ss_req` at the end of a wait. The bench measures the tick count of each wait exactly. A stale count after disable or after a failed attempt shows up on the following wait. The bench compares against a behavioural model on every clock, so any of these errors is caught within one cycle of its first visible effect.

// File: rtl/hiccup_pkg.sv
package hiccup_pkg;

    localparam int VID_W = 5;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SOFT = 2'd1,
        ST_RUN  = 2'd2,
        ST_WAIT = 2'd3
    } seq_state_e;

    // all-ones voltage code is the regulator-off request
    function automatic logic vid_is_off(input logic [VID_W-1:0] code);
        return &code;
    endfunction

    function automatic logic state_tristates(input seq_state_e s);
        return (s == ST_IDLE) || (s == ST_WAIT);
    endfunction

endpackage

// File: rtl/hiccup_wait_ctr.sv
module hiccup_wait_ctr #(
    parameter int WAIT_TICKS = 2048
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    output logic expire
);
    localparam int CW = (WAIT_TICKS > 1) ? $clog2(WAIT_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(WAIT_TICKS - 1);

    logic [CW-1:0] cnt;

    assign expire = run && tick && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run || expire) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R4: a cycle with no tick leaves the count unchanged
    p_cnt_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (run && !tick) |=> (cnt == $past(cnt)));

    // R3: the count never passes the last tick index
    p_cnt_range_r3: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

    // R3: expiry restarts the count
    p_expire_clear_r3: assert property (@(posedge clk) disable iff (rst)
        expire |=> (cnt == '0));

endmodule

// File: rtl/hiccup_ctrl.sv
module hiccup_ctrl
    import hiccup_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       oc,
    input  logic       vid_off,
    input  logic       ss_done,
    input  logic       ss_fail,
    input  logic       expire,
    output seq_state_e state,
    output logic       fault
);
    seq_state_e state_n;
    logic       fault_n;

    always_comb begin
        state_n = state;
        fault_n = fault;
        if (!en) begin
            state_n = ST_IDLE;
            fault_n = 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (!vid_off) state_n = ST_SOFT;
                ST_SOFT: begin
                    if (oc || ss_fail) begin
                        state_n = ST_WAIT;
                        fault_n = 1'b1;
                    end else if (ss_done) begin
                        state_n = ST_RUN;
                        fault_n = 1'b0;
                    end
                end
                ST_RUN: begin
                    if (oc) begin
                        state_n = ST_WAIT;
                        fault_n = 1'b1;
                    end
                end
                ST_WAIT: if (expire) state_n = ST_SOFT;
                default: state_n = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            fault <= 1'b0;
        end else begin
            state <= state_n;
            fault <= fault_n;
        end
    end

    // R10: disable returns to idle with fault cleared
    p_disable_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !en |=> (state == ST_IDLE && !fault));

    // R7: simultaneous done and fail never reaches running
    p_fail_wins_r7: assert property (@(posedge clk) disable iff (rst)
        (en && state == ST_SOFT && ss_fail && ss_done) |=> (state == ST_WAIT));

    // R3: soft-start is only entered from the wait on expiry
    p_wait_exit_r3: assert property (@(posedge clk) disable iff (rst)
        (en && state == ST_WAIT && !expire) |=> (state == ST_WAIT));

endmodule

// File: rtl/hiccup_phase_gate.sv
module hiccup_phase_gate #(
    parameter int NUM_PHASES = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  off_state,
    input  logic                  vid_off,
    output logic [NUM_PHASES-1:0] pwm_hiz
);
    logic hiz_all;
    assign hiz_all = off_state || vid_off;

    for (genvar g = 0; g < NUM_PHASES; g++) begin : g_phase
        assign pwm_hiz[g] = hiz_all;
    end

    // R2: phases are never split between driven and tri-stated
    p_phase_uniform_r2: assert property (@(posedge clk) disable iff (rst)
        (pwm_hiz == '0) || (&pwm_hiz));

    // R8: off code always tri-states every phase
    p_vid_off_r8: assert property (@(posedge clk) disable iff (rst)
        vid_off |-> (&pwm_hiz));

endmodule

// File: rtl/hiccup_seq.sv
module hiccup_seq
    import hiccup_pkg::*;
#(
    parameter int NUM_PHASES = 4,
    parameter int WAIT_TICKS = 2048
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  en,
    input  logic                  tick,
    input  logic                  oc,
    input  logic [4:0]            vid,
    input  logic                  ss_done,
    input  logic                  ss_fail,
    output logic [NUM_PHASES-1:0] pwm_hiz,
    output logic                  ss_req,
    output logic                  fault
);
    seq_state_e state;
    logic       vid_off;
    logic       expire;
    logic       waiting;

    assign vid_off = vid_is_off(vid);
    assign waiting = (state == ST_WAIT);
    assign ss_req  = (state == ST_SOFT);

    hiccup_wait_ctr #(.WAIT_TICKS(WAIT_TICKS)) u_wait (
        .clk    (clk),
        .rst    (rst),
        .run    (waiting),
        .tick   (tick),
        .expire (expire)
    );

    hiccup_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .oc      (oc),
        .vid_off (vid_off),
        .ss_done (ss_done),
        .ss_fail (ss_fail),
        .expire  (expire),
        .state   (state),
        .fault   (fault)
    );

    hiccup_phase_gate #(.NUM_PHASES(NUM_PHASES)) u_gate (
        .clk       (clk),
        .rst       (rst),
        .off_state (state_tristates(state)),
        .vid_off   (vid_off),
        .pwm_hiz   (pwm_hiz)
    );

    // R2: overcurrent while running shuts every phase off next clock
    p_oc_shutdown_r2: assert property (@(posedge clk) disable iff (rst)
        (en && oc && !pwm_hiz[0] && !ss_req) |=> ((&pwm_hiz) && fault));

    // R9: fault holds until a clean soft-start completion
    p_fault_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (en && fault && !(ss_req && ss_done)) |=> fault);

    // R10: disable leaves no request and all phases off
    p_disable_out_r10: assert property (@(posedge clk) disable iff (rst)
        !en |=> ((&pwm_hiz) && !ss_req && !fault));

endmodule

// File: tb/tb_hiccup_seq.sv
module tb_hiccup_seq;
    localparam int NP = 4;
    localparam int WT = 2048;

    logic          clk = 1'b0;
    logic          rst, en, tick, oc, ss_done, ss_fail;
    logic [4:0]    vid;
    logic [NP-1:0] pwm_hiz;
    logic          ss_req, fault;

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    hiccup_seq #(.NUM_PHASES(NP), .WAIT_TICKS(WT)) dut (
        .clk(clk), .rst(rst), .en(en), .tick(tick), .oc(oc), .vid(vid),
        .ss_done(ss_done), .ss_fail(ss_fail),
        .pwm_hiz(pwm_hiz), .ss_req(ss_req), .fault(fault)
    );

    // behavioural reference: 0 idle, 1 soft-start, 2 running, 3 waiting
    int m_mode = 0;
    int m_ticks = 0;
    bit m_fault = 0;

    always @(posedge clk) begin
        if (rst || !en) begin
            m_mode = 0; m_ticks = 0; m_fault = 0;
        end else begin
            case (m_mode)
                0: if (vid != 5'h1f) m_mode = 1;
                1: if (oc || ss_fail) begin m_mode = 3; m_ticks = 0; m_fault = 1; end
                   else if (ss_done) begin m_mode = 2; m_fault = 0; end
                2: if (oc) begin m_mode = 3; m_ticks = 0; m_fault = 1; end
                3: if (tick) begin
                       m_ticks++;
                       if (m_ticks == WT) begin m_mode = 1; m_ticks = 0; end
                   end
                default: m_mode = 0;
            endcase
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // sample at falling edge, compare against the model
    task automatic step();
        logic [NP-1:0] e_hiz;
        @(negedge clk);
        e_hiz = (m_mode == 0 || m_mode == 3 || vid == 5'h1f) ? '1 : '0;
        check(pwm_hiz == e_hiz, "R2/R8 pwm_hiz", int'(pwm_hiz), int'(e_hiz));
        check(ss_req == (m_mode == 1), "R5/R11 ss_req", int'(ss_req), int'(m_mode == 1));
        check(fault == m_fault, "R9 fault", int'(fault), int'(m_fault));
    endtask

    // drive ticks during a wait; returns ticks driven before ss_req appears
    task automatic run_wait(input int quiet, input int gap, input int stop_at, output int ticks);
        int c = 0;
        ticks = 0;
        forever begin
            step();
            if (ss_req || (stop_at > 0 && ticks == stop_at) || c > 20000) break;
            tick = (c >= quiet) && (((c - quiet) % (gap + 1)) == 0);
            if (tick) ticks++;
            c++;
        end
        tick = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            miscompares++;
            $display("FAIL watchdog all requirements actual=%0d expected<150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        int t;
        rst = 1; en = 0; tick = 0; oc = 0; vid = 5'h0a; ss_done = 0; ss_fail = 0;
        repeat (3) step();
        rst = 0;
        step();
        // R1: reset state
        check(&pwm_hiz && !ss_req && !fault, "R1 reset outputs", int'({pwm_hiz, ss_req, fault}), int'({{NP{1'b1}}, 2'b00}));

        // R11: start from idle
        en = 1;
        step();
        check(ss_req && !fault, "R11 start request", int'(ss_req), 1);
        // R5: phases driven during soft-start, done leads to running
        check(pwm_hiz == '0, "R5 driven in soft-start", int'(pwm_hiz), 0);
        ss_done = 1; step(); ss_done = 0;
        check(!ss_req && pwm_hiz == '0 && !fault, "R5 running", int'({pwm_hiz, ss_req}), 0);

        // R8: off code while running
        vid = 5'h1f; step();
        check(&pwm_hiz, "R8 off code tri-states", int'(pwm_hiz), (1 << NP) - 1);
        vid = 5'h05; step();
        check(pwm_hiz == '0, "R8 code release", int'(pwm_hiz), 0);

        // R2: overcurrent shutdown
        oc = 1; step(); oc = 0;
        check(&pwm_hiz && fault, "R2 shutdown", int'({pwm_hiz, fault}), int'({{NP{1'b1}}, 1'b1}));

        // R3/R4: quiet cycles then one tick per cycle
        run_wait(40, 0, 0, t);
        check(t == WT, "R3 wait length", t, WT);
        check(t == WT && ss_req, "R4 no advance without tick", t, WT);
        check(fault, "R9 fault held through wait", int'(fault), 1);

        // R6: fail strobe ends the attempt
        ss_fail = 1; step(); ss_fail = 0;
        check(&pwm_hiz && !ss_req, "R6 fail returns to wait", int'(ss_req), 0);
        run_wait(0, 1, 0, t);
        check(t == WT, "R6 full wait after fail", t, WT);

        // R7: done and fail together count as failure
        ss_done = 1; ss_fail = 1; step(); ss_done = 0; ss_fail = 0;
        check(!ss_req && &pwm_hiz && fault, "R7 fail wins", int'({ss_req, fault}), 1);
        run_wait(0, 2, 0, t);
        check(t == WT, "R7 wait after tie", t, WT);

        // R6: overcurrent during soft-start
        oc = 1; step(); oc = 0;
        check(!ss_req && fault, "R6 oc in soft-start", int'(ss_req), 0);

        // R10: disable mid-wait then re-enable
        run_wait(0, 0, 300, t);
        en = 0; step();
        check(&pwm_hiz && !ss_req && !fault, "R10 disable idle", int'({ss_req, fault}), 0);
        en = 1; step();
        ss_done = 1; step(); ss_done = 0;
        check(!fault && pwm_hiz == '0, "R10 restart runs", int'(pwm_hiz), 0);
        oc = 1; step(); oc = 0;
        run_wait(0, 0, 0, t);
        check(t == WT, "R10 count cleared by disable", t, WT);

        // R9: successful attempt clears fault
        ss_done = 1; step(); ss_done = 0;
        check(!fault && !ss_req, "R9 fault cleared on success", int'(fault), 0);

        // R8: off code keeps idle from starting
        en = 0; step();
        vid = 5'h1f; en = 1;
        repeat (5) step();
        check(!ss_req && &pwm_hiz, "R8 idle held by off code", int'(ss_req), 0);
        vid = 5'h10; step();
        check(ss_req, "R11 start after code release", int'(ss_req), 1);
        step();

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule